// File: doc/BRIEF.md
# Card Command Issue and Status Register

This block sits between a CPU register port and the command side of a memory-card host. Software writes a 32-bit argument in two 16-bit halves, then writes a 16-bit command word. The block decodes the command word and presents the index and argument to a card-side engine over a valid/ready handshake. It then waits for the engine to hand back a response byte count and up to sixteen response bytes.

Once the response arrives, the block checks its length against the response type, tests the card status bits for errors, and packs the bytes into eight 16-bit response words. It sets completion and error flags in a 15-bit status register and drives an interrupt from the enabled status bits. A command that moves data also raises a transfer-active flag, latches the transfer direction and pulses a flush to the data FIFO.

Software clears status bits by writing ones to them. A command with the init flag and index 0 sends nothing to the card and only reports completion.

Top module: `mmc_cmd_status`

## Requirements
- R1: The command word is decoded as index in bits 5:0, init flag bit 7, response type bits 10:8, busy flag bit 11, command type bits 13:12 and direction bit 15. An accepted command drives `card_cmd_valid` with that index and the 32-bit argument (high half at register 2, low half at register 1) and holds it until `card_cmd_ready`.
- R2: A command write (register 0) is ignored while the enable bit (register 5 bit 0) is clear: the card sees no request, and both the status register and the stored command word are unchanged.
- R3: An accepted command write clears all eight response words (registers 8 to 15) before the command is sent.
- R4: A command with the init flag set and index 0 sends nothing to the card, sets status bit 0 only, and leaves the block idle.
- R5: For response types 1, 3 and 6, a returned length below 4 is a timeout. For type 2, a length below 16 is a timeout. A timeout sets status bit 7, does not set bit 0, and leaves the response words zero.
- R6: For type 1, with or without the busy flag, bytes 0 to 3 form a big-endian card status word. Any set bit in mask 0xFDF90000 sets status bit 14.
- R7: For type 6, bytes 2 and 3 form a big-endian 16-bit value. Any set bit in mask 0xE008 sets status bit 14.
- R8: For type 3, status bit 12 is set when bit 31 of the big-endian word from bytes 0 to 3 is clear, and is not set when that bit is set.
- R9: A response without a timeout sets status bit 0. For index 12 it sets bits 0 and 2. Response types 0, 4, 5 and 7 expect no bytes and complete the same way.
- R10: Response bytes are packed in pairs, high byte first, into the response words. Bytes 0 and 1 go to word 7 (register 15), bytes 2 and 3 to word 6, and so on. Bytes beyond the length expected for the type read as zero.
- R11: Writing the status register (register 3) clears each bit written as 1 and leaves the others. A flag set in the same cycle wins over the clear.
- R12: The interrupt-enable register (register 4) keeps 15 bits. `irq` is high exactly when some status bit and its enable bit are both 1.
- R13: An accepted command of type 3 sets `xfer_active`, latches bit 15 into `xfer_dir` and pulses `fifo_flush` for one cycle. Any other accepted command clears `xfer_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| card_cmd_valid | output | 1 | Command request to the card engine |
| card_cmd_ready | input | 1 | Card engine has taken the request |
| card_cmd_index | output | 6 | Command index of the request |
| card_cmd_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Response available from the card engine |
| card_rsp_len | input | 5 | Number of response bytes returned |
| card_rsp_data | input | 128 | Response bytes, byte i in bits 8i+7:8i |
| busy | output | 1 | A command is outstanding |
| xfer_active | output | 1 | A data-moving command is in progress |
| xfer_dir | output | 1 | Latched direction of the data command |
| fifo_flush | output | 1 | One-cycle pulse to empty the data FIFO |
| irq | output | 1 | Masked status interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Stored words, the cleared response words, `xfer_active` and the R4 status flag can therefore be read at the falling edge that follows. The request appears on `card_cmd_valid` in that same cycle. Status flags and response words from a reply appear one edge after `card_rsp_valid` is sampled, which is the edge where `busy` drops. The bench waits for `busy` low before it pops expected register values from its scoreboard. It reads registers and samples `irq` only on falling edges, so no check lands on the edge where a value changes.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // Command word layout, msb first
    typedef struct packed {
        logic       dir;
        logic       spare14;
        logic [1:0] ctype;
        logic       busy;
        logic [2:0] rtype;
        logic       init;
        logic       spare6;
        logic [5:0] idx;
    } cmd_word_t;

    localparam logic [3:0] A_CMD    = 4'd0;
    localparam logic [3:0] A_ARG_LO = 4'd1;
    localparam logic [3:0] A_ARG_HI = 4'd2;
    localparam logic [3:0] A_STAT   = 4'd3;
    localparam logic [3:0] A_IRQEN  = 4'd4;
    localparam logic [3:0] A_CTRL   = 4'd5;

    localparam int SB_DONE  = 0;
    localparam int SB_STOP  = 2;
    localparam int SB_TOUT  = 7;
    localparam int SB_OCRB  = 12;
    localparam int SB_CERR  = 14;

    localparam logic [2:0] RT_NONE = 3'd0;
    localparam logic [2:0] RT_R1   = 3'd1;
    localparam logic [2:0] RT_R2   = 3'd2;
    localparam logic [2:0] RT_R3   = 3'd3;
    localparam logic [2:0] RT_R6   = 3'd6;

    localparam logic [1:0] CT_DATA = 2'd3;

endpackage

// File: rtl/mmc_cmd_decode.sv
module mmc_cmd_decode
    import mmc_cmd_pkg::*;
(
    input  logic [15:0] word_i,
    output cmd_word_t   fields_o,
    output logic        is_boot_o,
    output logic        is_data_o
);
    assign fields_o  = cmd_word_t'(word_i);
    assign is_boot_o = fields_o.init && (fields_o.idx == 6'd0);
    assign is_data_o = (fields_o.ctype == CT_DATA);
endmodule

// File: rtl/mmc_rsp_classify.sv
module mmc_rsp_classify
    import mmc_cmd_pkg::*;
#(
    parameter int          NUM_WORDS   = 8,
    parameter int          STAT_W      = 15,
    parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
    parameter logic [15:0] R6_ERR_MASK = 16'hE008,
    localparam int         NB          = 2 * NUM_WORDS,
    localparam int         LEN_W       = $clog2(NB + 1)
) (
    input  logic [2:0]                  rtype_i,
    input  logic [5:0]                  idx_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic [8*NB-1:0]             data_i,
    output logic                        timeout_o,
    output logic [STAT_W-1:0]           set_mask_o,
    output logic [NUM_WORDS-1:0][15:0]  words_o
);
    logic          has_rsp;
    logic [LEN_W:0] exp_len;
    logic [7:0]    byte_m [NB];
    logic [31:0]   card_stat;
    logic [15:0]   rca_stat;
    logic          err;
    logic          ocr_busy;

    always_comb begin
        has_rsp = (rtype_i == RT_R1) || (rtype_i == RT_R2) ||
                  (rtype_i == RT_R3) || (rtype_i == RT_R6);
        exp_len = (rtype_i == RT_R2) ? (LEN_W+1)'(NB) : (LEN_W+1)'(4);
        timeout_o = has_rsp && ({1'b0, len_i} < exp_len);
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_m[b] = (has_rsp && !timeout_o && (b < int'(exp_len)))
                           ? data_i[8*b +: 8] : 8'h00;
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        assign words_o[NUM_WORDS-1-k] = {byte_m[2*k], byte_m[2*k+1]};
    end

    always_comb begin
        card_stat = {byte_m[0], byte_m[1], byte_m[2], byte_m[3]};
        rca_stat  = {byte_m[2], byte_m[3]};
        err = ((rtype_i == RT_R1) && ((card_stat & R1_ERR_MASK) != '0)) ||
              ((rtype_i == RT_R6) && ((rca_stat  & R6_ERR_MASK) != '0));
        ocr_busy = (rtype_i == RT_R3) && !timeout_o && !card_stat[31];
        set_mask_o = '0;
        if (timeout_o) begin
            set_mask_o[SB_TOUT] = 1'b1;
        end else begin
            set_mask_o[SB_DONE] = 1'b1;
            set_mask_o[SB_STOP] = (idx_i == 6'd12);
            set_mask_o[SB_CERR] = err;
            set_mask_o[SB_OCRB] = ocr_busy;
        end
    end
endmodule

// File: rtl/mmc_cmd_status.sv
module mmc_cmd_status
    import mmc_cmd_pkg::*;
#(
    parameter int          NUM_RSP_WORDS = 8,
    parameter int          STAT_W        = 15,
    parameter logic [31:0] R1_ERR_MASK   = 32'hFDF9_0000,
    parameter logic [15:0] R6_ERR_MASK   = 16'hE008,
    localparam int         RSP_BYTES     = 2 * NUM_RSP_WORDS,
    localparam int         LEN_W         = $clog2(RSP_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [3:0]             reg_addr,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    output logic                   card_cmd_valid,
    input  logic                   card_cmd_ready,
    output logic [5:0]             card_cmd_index,
    output logic [31:0]            card_cmd_arg,
    input  logic                   card_rsp_valid,
    input  logic [LEN_W-1:0]       card_rsp_len,
    input  logic [8*RSP_BYTES-1:0] card_rsp_data,
    output logic                   busy,
    output logic                   xfer_active,
    output logic                   xfer_dir,
    output logic                   fifo_flush,
    output logic                   irq
);
    localparam logic [3:0] A_RSP_BASE = 4'd8;

    typedef struct packed {
        seq_state_e                     st;
        logic [15:0]                    last_cmd;
        logic [31:0]                    arg;
        logic [STAT_W-1:0]              status;
        logic [STAT_W-1:0]              irq_en;
        logic                           en;
        logic [NUM_RSP_WORDS-1:0][15:0] rsp;
        logic [5:0]                     idx;
        logic [2:0]                     rtype;
        logic                           xact;
        logic                           xdir;
        logic                           flush;
    } regs_t;

    regs_t s_q, s_d;

    cmd_word_t                      wr_fields;
    logic                           wr_boot;
    logic                           wr_data;
    logic                           rsp_timeout;
    logic [STAT_W-1:0]              rsp_set;
    logic [NUM_RSP_WORDS-1:0][15:0] rsp_words;
    logic                           cmd_accept;
    logic                           rsp_take;

    mmc_cmd_decode u_decode (
        .word_i    (reg_wdata),
        .fields_o  (wr_fields),
        .is_boot_o (wr_boot),
        .is_data_o (wr_data)
    );

    mmc_rsp_classify #(
        .NUM_WORDS   (NUM_RSP_WORDS),
        .STAT_W      (STAT_W),
        .R1_ERR_MASK (R1_ERR_MASK),
        .R6_ERR_MASK (R6_ERR_MASK)
    ) u_classify (
        .rtype_i    (s_q.rtype),
        .idx_i      (s_q.idx),
        .len_i      (card_rsp_len),
        .data_i     (card_rsp_data),
        .timeout_o  (rsp_timeout),
        .set_mask_o (rsp_set),
        .words_o    (rsp_words)
    );

    always_comb begin
        cmd_accept = reg_wr && (reg_addr == A_CMD) && s_q.en && (s_q.st == SEQ_IDLE);
        rsp_take   = (s_q.st == SEQ_WAIT) && card_rsp_valid;
    end

    always_comb begin
        s_d = s_q;
        s_d.flush = 1'b0;

        if (reg_wr) begin
            unique case (reg_addr)
                A_ARG_LO: s_d.arg[15:0]  = reg_wdata;
                A_ARG_HI: s_d.arg[31:16] = reg_wdata;
                A_STAT:   s_d.status     = s_q.status & ~reg_wdata[STAT_W-1:0];
                A_IRQEN:  s_d.irq_en     = reg_wdata[STAT_W-1:0];
                A_CTRL:   s_d.en         = reg_wdata[0];
                default: ;
            endcase
        end

        if (cmd_accept) begin
            s_d.last_cmd = reg_wdata;
            s_d.rsp      = '0;
            if (wr_boot) begin
                s_d.status[SB_DONE] = 1'b1;
            end else begin
                s_d.st    = SEQ_ISSUE;
                s_d.idx   = wr_fields.idx;
                s_d.rtype = wr_fields.rtype;
                if (wr_data) begin
                    s_d.xact  = 1'b1;
                    s_d.xdir  = wr_fields.dir;
                    s_d.flush = 1'b1;
                end else begin
                    s_d.xact  = 1'b0;
                end
            end
        end

        if ((s_q.st == SEQ_ISSUE) && card_cmd_ready) begin
            s_d.st = SEQ_WAIT;
        end

        if (rsp_take) begin
            s_d.st = SEQ_IDLE;
            if (!rsp_timeout) begin
                s_d.rsp = rsp_words;
            end
            s_d.status = s_d.status | rsp_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = 16'h0000;
        if (reg_addr >= A_RSP_BASE) begin
            if (int'(reg_addr - A_RSP_BASE) < NUM_RSP_WORDS)
                reg_rdata = s_q.rsp[3'(reg_addr - A_RSP_BASE)];
        end else begin
            case (reg_addr)
                A_CMD:    reg_rdata = s_q.last_cmd;
                A_ARG_LO: reg_rdata = s_q.arg[15:0];
                A_ARG_HI: reg_rdata = s_q.arg[31:16];
                A_STAT:   reg_rdata = {{(16-STAT_W){1'b0}}, s_q.status};
                A_IRQEN:  reg_rdata = {{(16-STAT_W){1'b0}}, s_q.irq_en};
                A_CTRL:   reg_rdata = {15'd0, s_q.en};
                default:  reg_rdata = 16'h0000;
            endcase
        end
    end

    assign card_cmd_valid = (s_q.st == SEQ_ISSUE);
    assign card_cmd_index = s_q.idx;
    assign card_cmd_arg   = s_q.arg;
    assign busy           = (s_q.st != SEQ_IDLE);
    assign xfer_active    = s_q.xact;
    assign xfer_dir       = s_q.xdir;
    assign fifo_flush     = s_q.flush;
    assign irq            = |(s_q.status & s_q.irq_en);

    assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (card_cmd_valid && !card_cmd_ready) |=> (card_cmd_valid && $stable(card_cmd_index)));

    assert_disabled_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CMD && !s_q.en && s_q.st == SEQ_IDLE)
        |=> (!busy && $stable(s_q.last_cmd)));

    assert_rsp_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (s_q.rsp == '0));

    assert_boot_no_card_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && wr_boot) |=> (!card_cmd_valid && s_q.status[SB_DONE]));

    assert_timeout_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && rsp_timeout) |=> (s_q.status[SB_TOUT] && !busy));

    assert_data_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && wr_data && !wr_boot) |=> (xfer_active && fifo_flush));

    assert_irqen_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IRQEN) |=> (s_q.irq_en == $past(reg_wdata[STAT_W-1:0])));
endmodule

// File: tb/mmc_cmd_status_tb_top.sv
module mmc_cmd_status_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_wr;
    logic [3:0]   reg_addr;
    logic [15:0]  reg_wdata;
    logic [15:0]  reg_rdata;
    logic         card_cmd_valid;
    logic         card_cmd_ready;
    logic [5:0]   card_cmd_index;
    logic [31:0]  card_cmd_arg;
    logic         card_rsp_valid;
    logic [4:0]   card_rsp_len;
    logic [127:0] card_rsp_data;
    logic         busy, xfer_active, xfer_dir, fifo_flush, irq;

    int checks = 0;
    int failures = 0;
    int req_count = 0;
    logic [5:0]   seen_idx;
    logic [31:0]  seen_arg;
    logic [4:0]   cfg_len;
    logic [127:0] cfg_data;

    typedef struct {
        string       tag;
        logic [3:0]  addr;
        logic [15:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    mmc_cmd_status dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_cmd_valid(card_cmd_valid), .card_cmd_ready(card_cmd_ready),
        .card_cmd_index(card_cmd_index), .card_cmd_arg(card_cmd_arg),
        .card_rsp_valid(card_rsp_valid), .card_rsp_len(card_rsp_len),
        .card_rsp_data(card_rsp_data), .busy(busy), .xfer_active(xfer_active),
        .xfer_dir(xfer_dir), .fifo_flush(fifo_flush), .irq(irq)
    );

    function automatic logic [15:0] mk(input int idx, input bit init, input int rt,
                                       input bit bsy, input int ct, input bit dir);
        return {dir, 1'b0, 2'(ct), bsy, 3'(rt), init, 1'b0, 6'(idx)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic issue(input logic [15:0] cmd);
        wr(4'd0, cmd);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    task automatic push(input string tag, input logic [3:0] a, input logic [15:0] e);
        sb_item_t it;
        it.tag = tag; it.addr = a; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic push_words(input string tag, input logic [127:0] bytes, input int n);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] hi, lo;
            hi = (2*k < n)   ? bytes[16*k +: 8]     : 8'h00;
            lo = (2*k+1 < n) ? bytes[16*k+8 +: 8]   : 8'h00;
            push(tag, 4'(15 - k), {hi, lo});
        end
    endtask

    task automatic drain();
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] v;
            it = sb_q.pop_front();
            rd(it.addr, v);
            chk($sformatf("%s reg%0d", it.tag, it.addr), 32'(v), 32'(it.exp));
        end
    endtask

    // card engine model
    initial begin
        card_cmd_ready = 1'b0;
        card_rsp_valid = 1'b0;
        card_rsp_len   = '0;
        card_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (card_cmd_valid === 1'b1 && !card_cmd_ready) begin
                req_count++;
                seen_idx = card_cmd_index;
                seen_arg = card_cmd_arg;
                card_cmd_ready = 1'b1;
                @(negedge clk);
                card_cmd_ready = 1'b0;
                repeat (2) @(negedge clk);
                card_rsp_len   = cfg_len;
                card_rsp_data  = cfg_data;
                card_rsp_valid = 1'b1;
                @(negedge clk);
                card_rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] seq;
        int rc;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        cfg_len = 5'd4; cfg_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk);
        chk("reset busy", 32'(busy), 0);
        chk("reset irq", 32'(irq), 0);
        chk("reset card_cmd_valid", 32'(card_cmd_valid), 0);
        push("reset status", 4'd3, 16'h0000);
        push_words("reset rsp R3", '0, 0);
        drain();

        // R2: disabled, command ignored
        rc = req_count;
        issue(mk(17, 0, 1, 0, 2, 0));
        repeat (6) @(negedge clk);
        chk("R2 no card request when disabled", 32'(req_count), 32'(rc));
        push("R2 status unchanged", 4'd3, 16'h0000);
        push("R2 cmd word not stored", 4'd0, 16'h0000);
        drain();

        wr(4'd5, 16'h0001);
        wr(4'd1, 16'h1234);
        wr(4'd2, 16'hCAFE);

        // R1/R6/R9/R10: type 1 good response
        cfg_len = 5'd4; cfg_data = '0;
        cfg_data[31:0] = {8'h00, 8'h09, 8'h00, 8'h00};
        issue(mk(17, 0, 1, 0, 2, 0));
        chk("R1 card saw index", 32'(seen_idx), 32'd17);
        chk("R1 card saw argument", seen_arg, 32'hCAFE1234);
        push("R9 R6 type1 ok done only", 4'd3, 16'h0001);
        push_words("R10 type1 packing", cfg_data, 4);
        push("R1 stored command word", 4'd0, mk(17, 0, 1, 0, 2, 0));
        drain();

        // R11: write-1-to-clear
        wr(4'd3, 16'h0001);
        push("R11 w1c clears", 4'd3, 16'h0000);
        drain();

        // R6 error with busy flag, R12 irq
        wr(4'd4, 16'hC000);
        push("R12 irq enable keeps 15 bits", 4'd4, 16'h4000);
        drain();
        cfg_data = '0; cfg_data[7:0] = 8'h80;
        issue(mk(7, 0, 1, 1, 2, 0));
        push("R6 error sets bit14", 4'd3, 16'h4001);
        drain();
        chk("R12 irq raised", 32'(irq), 1);
        wr(4'd3, 16'h0001);
        push("R11 w1c keeps unwritten bits", 4'd3, 16'h4000);
        drain();
        wr(4'd3, 16'h7FFF);
        @(negedge clk);
        chk("R12 irq dropped after clear", 32'(irq), 0);

        // R5: type 2 short
        for (int b = 0; b < 16; b++) seq[8*b +: 8] = 8'(8'h10 + b);
        cfg_len = 5'd15; cfg_data = seq;
        issue(mk(2, 0, 2, 0, 1, 0));
        push("R5 type2 short timeout", 4'd3, 16'h0080);
        push_words("R5 rsp zero after timeout", '0, 0);
        drain();
        wr(4'd3, 16'h7FFF);

        // R5: type 1 short
        cfg_len = 5'd3;
        issue(mk(13, 0, 1, 0, 2, 0));
        push("R5 type1 short timeout", 4'd3, 16'h0080);
        drain();
        wr(4'd3, 16'h7FFF);

        // R10: type 2 full packing
        cfg_len = 5'd16;
        issue(mk(2, 0, 2, 0, 1, 0));
        push("R9 type2 done", 4'd3, 16'h0001);
        push_words("R10 type2 packing", seq, 16);
        drain();
        wr(4'd3, 16'h7FFF);

        // R3 / R9: no-response type clears words
        issue(mk(5, 0, 0, 0, 0, 0));
        push("R9 no-response done", 4'd3, 16'h0001);
        push_words("R3 rsp cleared", '0, 0);
        drain();
        wr(4'd3, 16'h7FFF);

        // R8: type 3
        cfg_len = 5'd4; cfg_data = '0;
        cfg_data[31:0] = {8'h00, 8'h80, 8'hFF, 8'h00};
        issue(mk(41, 0, 3, 0, 1, 0));
        push("R8 ocr msb clear sets bit12", 4'd3, 16'h1001);
        push_words("R10 type3 packing", cfg_data, 4);
        drain();
        wr(4'd3, 16'h7FFF);
        cfg_data[7:0] = 8'h80;
        issue(mk(41, 0, 3, 0, 1, 0));
        push("R8 ocr msb set no bit12", 4'd3, 16'h0001);
        drain();
        wr(4'd3, 16'h7FFF);

        // R7: type 6
        cfg_data = '0; cfg_data[31:0] = {8'h00, 8'h20, 8'h34, 8'h12};
        issue(mk(3, 0, 6, 0, 1, 0));
        push("R7 type6 error", 4'd3, 16'h4001);
        drain();
        wr(4'd3, 16'h7FFF);
        cfg_data[31:0] = {8'h01, 8'h00, 8'h34, 8'h12};
        issue(mk(3, 0, 6, 0, 1, 0));
        push("R7 type6 no error", 4'd3, 16'h0001);
        drain();
        wr(4'd3, 16'h7FFF);

        // R9: index 12
        cfg_data = '0;
        issue(mk(12, 0, 1, 1, 2, 0));
        push("R9 stop command bits0 and 2", 4'd3, 16'h0005);
        drain();
        wr(4'd3, 16'h7FFF);

        // R4: init with index 0
        rc = req_count;
        issue(mk(0, 1, 0, 0, 0, 0));
        chk("R4 busy stays low", 32'(busy), 0);
        repeat (6) @(negedge clk);
        chk("R4 no card request", 32'(req_count), 32'(rc));
        push("R4 done only", 4'd3, 16'h0001);
        drain();
        wr(4'd3, 16'h7FFF);

        // R13: data command
        wr(4'd0, mk(18, 0, 1, 0, 3, 1));
        chk("R13 flush pulse", 32'(fifo_flush), 1);
        chk("R13 xfer_active set", 32'(xfer_active), 1);
        chk("R13 xfer_dir latched", 32'(xfer_dir), 1);
        @(negedge clk);
        chk("R13 flush one cycle", 32'(fifo_flush), 0);
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        issue(mk(13, 0, 1, 0, 2, 0));
        chk("R13 non-data clears xfer_active", 32'(xfer_active), 0);

        // R12: status set but disabled in enable register
        wr(4'd4, 16'h0000);
        @(negedge clk);
        chk("R12 irq low when masked", 32'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule